// File: doc/BRIEF.md
# Block-Partitioned Synchronous Word Memory

A single-port synchronous memory of 32-bit words. The storage is split into independently enabled sub-arrays. Each sub-array row holds two 32-bit words side by side. On every clock edge the port takes one command: a read, a write or nothing. The command is built from a read strobe, a write strobe, an address and a write word. Read data comes back on a registered output word.

The address is split into three fields. The upper field is decoded to a one-hot sub-array enable. The middle field is decoded to a one-hot wordline. The lowest bit picks one of the two words in the row. Only the enabled sub-array is touched by an access. Both one-hot vectors leave the block, so activity gating can be observed from outside.

A sleep input forces every enable and wordline low and masks both strobes. The stored contents are kept while sleep is high. The defaults (`BLK_BITS=3`, `ROW_BITS=4`) give 8 sub-arrays of 16 rows, which is 256 words. Setting `BLK_BITS=6` and `ROW_BITS=8` gives 64 sub-arrays of 256 rows: 32768 words, or 1 Mb.

Top module: `blksram_top`

## Requirements
- R1: While `rst` is high, `rd_data` is cleared to zero on each clock edge.
- R2: A write stores `wr_data` at `addr`. A later read of that address returns the word stored there.
- R3: `rd_data` changes only on the clock edge where `rd_en` is sampled high. It shows the addressed word from that edge onward, so the read latency is one edge.
- R4: When neither strobe is high, `rd_data` holds its value, and `blk_en` and `wordline` are all zero.
- R5: If `rd_en` and `wr_en` are high together, only the write is performed and `rd_data` stays unchanged.
- R6: While `sleep` is high, `blk_en` and `wordline` are zero and both strobes are ignored. No word is written, `rd_data` holds, and the contents survive the sleep.
- R7: During an access, `blk_en` has exactly one bit set, at index `addr[AW-1:ROW_BITS+1]`.
- R8: During an access, `wordline` has exactly one bit set, at index `addr[ROW_BITS:1]`.
- R9: `addr[0]` selects the low word (0) or the high word (1) of a row. A write to one word of a row leaves the other word of that row unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset of the output word |
| sleep | input | 1 | Low-power hold: masks strobes, forces decoders low |
| addr | input | AW = BLK_BITS+ROW_BITS+1 | Word address: sub-array, row, word-in-row |
| wr_data | input | 32 | Word to store |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe (wins over read) |
| rd_data | output | 32 | Registered read word |
| blk_en | output | 2**BLK_BITS | One-hot sub-array enable for the current cycle |
| wordline | output | 2**ROW_BITS | One-hot row wordline for the current cycle |

## Verification
`blk_en` and `wordline` are combinational from the inputs of the same cycle. The bench drives inputs on the falling edge and samples these two vectors one time unit later, before the rising edge. `rd_data` is due one rising edge after a read is sampled, so it is checked on the next falling edge. One extra check, made before the rising edge, confirms that the old value is still present then. Stores take effect at that same edge, and every address is swept for both writes and reads against an arithmetic reference pattern.

// File: rtl/sram_pkg.sv
package sram_pkg;

    localparam int WORD_W      = 32;
    localparam int WORDS_PER_ROW = 2;
    localparam int COL_BITS    = 1;

    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_e;

    typedef struct packed {
        op_e   op;
        word_t data;
    } cmd_t;

    // Write beats read; sleep masks everything.
    function automatic op_e resolve_op(input logic slp, input logic rd, input logic wr);
        if (slp)      return OP_IDLE;
        else if (wr)  return OP_WRITE;
        else if (rd)  return OP_READ;
        else          return OP_IDLE;
    endfunction

endpackage

// File: rtl/sram_onehot_dec.sv
module sram_onehot_dec #(
    parameter int IN_W = 3,
    localparam int OUT_N = 1 << IN_W
) (
    input  logic [IN_W-1:0]  sel,
    input  logic             en,
    output logic [OUT_N-1:0] onehot
);
    generate
        for (genvar i = 0; i < OUT_N; i++) begin : g_line
            assign onehot[i] = en && (sel == IN_W'(i));
        end
    endgenerate
endmodule

// File: rtl/sram_subarray.sv
module sram_subarray
    import sram_pkg::*;
#(
    parameter int ROW_BITS = 4,
    localparam int NROW = 1 << ROW_BITS,
    localparam int ROW_W = WORDS_PER_ROW * WORD_W
) (
    input  logic                clk,
    input  logic                sel,
    input  logic [ROW_BITS-1:0] row,
    input  logic                col,
    input  cmd_t                cmd,
    output word_t               rdata
);
    logic [ROW_W-1:0] cells [NROW];

    always_ff @(posedge clk) begin
        if (sel && cmd.op == OP_WRITE) begin
            cells[row][col*WORD_W +: WORD_W] <= cmd.data;
        end
    end

    // Output gated by the sub-array enable so the parent can OR the sub-arrays.
    always_comb begin
        rdata = '0;
        if (sel && cmd.op == OP_READ) begin
            rdata = cells[row][col*WORD_W +: WORD_W];
        end
    end
endmodule

// File: rtl/blksram_top.sv
module blksram_top
    import sram_pkg::*;
#(
    parameter int BLK_BITS = 3,
    parameter int ROW_BITS = 4,
    localparam int AW   = BLK_BITS + ROW_BITS + COL_BITS,
    localparam int NBLK = 1 << BLK_BITS,
    localparam int NROW = 1 << ROW_BITS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sleep,
    input  logic [AW-1:0]     addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic              wr_en,
    output logic [WORD_W-1:0] rd_data,
    output logic [NBLK-1:0]   blk_en,
    output logic [NROW-1:0]   wordline
);
    cmd_t                cmd;
    logic                active;
    logic [BLK_BITS-1:0] blk_idx;
    logic [ROW_BITS-1:0] row_idx;
    logic                col_sel;
    word_t               blk_rd [NBLK];
    word_t               rd_mux;

    assign blk_idx  = addr[AW-1 -: BLK_BITS];
    assign row_idx  = addr[ROW_BITS:1];
    assign col_sel  = addr[0];
    assign cmd.op   = resolve_op(sleep, rd_en, wr_en);
    assign cmd.data = wr_data;
    assign active   = (cmd.op != OP_IDLE);

    sram_onehot_dec #(.IN_W(BLK_BITS)) u_blk_dec (
        .sel(blk_idx), .en(active), .onehot(blk_en)
    );

    sram_onehot_dec #(.IN_W(ROW_BITS)) u_row_dec (
        .sel(row_idx), .en(active), .onehot(wordline)
    );

    generate
        for (genvar b = 0; b < NBLK; b++) begin : g_blk
            sram_subarray #(.ROW_BITS(ROW_BITS)) u_sub (
                .clk  (clk),
                .sel  (blk_en[b]),
                .row  (row_idx),
                .col  (col_sel),
                .cmd  (cmd),
                .rdata(blk_rd[b])
            );
        end
    endgenerate

    always_comb begin
        rd_mux = '0;
        for (int b = 0; b < NBLK; b++) begin
            rd_mux = rd_mux | blk_rd[b];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data <= '0;
        end else if (cmd.op == OP_READ) begin
            rd_data <= rd_mux;
        end
    end
endmodule

// File: rtl/sram_chk.sv
module sram_chk #(
    parameter int BLK_BITS = 3,
    parameter int ROW_BITS = 4,
    localparam int AW   = BLK_BITS + ROW_BITS + 1,
    localparam int NBLK = 1 << BLK_BITS,
    localparam int NROW = 1 << ROW_BITS
) (
    input logic            clk,
    input logic            rst,
    input logic            sleep,
    input logic [AW-1:0]   addr,
    input logic            rd_en,
    input logic            wr_en,
    input logic [31:0]     rd_data,
    input logic [NBLK-1:0] blk_en,
    input logic [NROW-1:0] wordline
);
    logic acc;
    assign acc = (rd_en || wr_en) && !sleep;

    // R7
    blk_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        acc |-> ($countones(blk_en) == 1 && blk_en[addr[AW-1 -: BLK_BITS]]));

    // R8
    wl_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        acc |-> ($countones(wordline) == 1 && wordline[addr[ROW_BITS:1]]));

    // R4
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (!rd_en && !wr_en) |-> (blk_en == '0 && wordline == '0));

    // R6
    sleep_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        sleep |-> (blk_en == '0 && wordline == '0));

    // R5
    out_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!rd_en || wr_en || sleep) |=> $stable(rd_data));
endmodule

bind blksram_top sram_chk #(.BLK_BITS(BLK_BITS), .ROW_BITS(ROW_BITS)) u_chk (
    .clk(clk), .rst(rst), .sleep(sleep), .addr(addr), .rd_en(rd_en),
    .wr_en(wr_en), .rd_data(rd_data), .blk_en(blk_en), .wordline(wordline)
);

// File: tb/tb_blksram_top.sv
module tb_blksram_top;
    localparam int CLK_PERIOD = 10;
    localparam int BLK_BITS = 3;
    localparam int ROW_BITS = 4;
    localparam int AW   = BLK_BITS + ROW_BITS + 1;
    localparam int NBLK = 1 << BLK_BITS;
    localparam int NROW = 1 << ROW_BITS;
    localparam int NW   = 1 << AW;

    logic clk = 0, rst = 1, sleep = 0, rd_en = 0, wr_en = 0;
    logic [AW-1:0] addr = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic [NBLK-1:0] blk_en;
    logic [NROW-1:0] wordline;

    int n_tests = 0, n_fail = 0;
    logic [31:0] model [NW];

    always #(CLK_PERIOD/2) clk = ~clk;

    blksram_top #(.BLK_BITS(BLK_BITS), .ROW_BITS(ROW_BITS)) dut (
        .clk(clk), .rst(rst), .sleep(sleep), .addr(addr), .wr_data(wr_data),
        .rd_en(rd_en), .wr_en(wr_en), .rd_data(rd_data), .blk_en(blk_en),
        .wordline(wordline)
    );

    function automatic logic [31:0] pat(input int a, input int salt);
        return (32'(a) * 32'h9E3779B1) ^ (32'(salt) << 20) ^ 32'h0000_5A5A;
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive at negedge, check decoders before the rising edge, return at next negedge.
    task automatic op(input logic s, input logic r, input logic w, input int a,
                      input logic [31:0] d, input bit chk_dec);
        sleep = s; rd_en = r; wr_en = w; addr = AW'(a); wr_data = d;
        #1;
        if (chk_dec) begin
            if (!s && (r || w)) begin
                check("R7", 64'(blk_en), 64'(NBLK'(1) << (a >> (ROW_BITS + 1))));
                check("R8", 64'(wordline), 64'(NROW'(1) << ((a >> 1) % NROW)));
            end else if (s) begin
                check("R6", 64'({blk_en, wordline}), 64'd0);
            end else begin
                check("R4", 64'({blk_en, wordline}), 64'd0);
            end
        end
        @(negedge clk);
        if (!s && w) model[a] = d;
    endtask

    initial begin
        repeat (400000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] hold;
        repeat (3) @(negedge clk);
        check("R1", 64'(rd_data), 64'd0);
        rst = 0;
        op(0, 0, 0, 0, 0, 1);
        check("R1 hold after reset", 64'(rd_data), 64'd0);

        // Fill every address, checking decoders each time (R7, R8).
        for (int a = 0; a < NW; a++) op(0, 0, 1, a, pat(a, 1), 1);
        // Read every address (R2, R9 word select).
        for (int a = 0; a < NW; a++) begin
            op(0, 1, 0, a, 32'hDEAD_BEEF, 1);
            check("R2", 64'(rd_data), 64'(model[a]));
        end

        // R3: value only changes at the edge.
        op(0, 1, 0, 5, 0, 0);
        sleep = 0; rd_en = 1; wr_en = 0; addr = AW'(200);
        #1 check("R3 before edge", 64'(rd_data), 64'(model[5]));
        @(negedge clk);
        check("R3 after edge", 64'(rd_data), 64'(model[200]));

        // R4: idle cycles hold the output.
        hold = rd_data;
        for (int i = 0; i < 4; i++) begin
            op(0, 0, 0, i * 37, 32'h1234_5678, 1);
            check("R4", 64'(rd_data), 64'(hold));
        end

        // R5: read+write together -> write only.
        op(0, 1, 1, 77, 32'hCAFE_0077, 1);
        check("R5 out unchanged", 64'(rd_data), 64'(hold));
        op(0, 1, 0, 77, 0, 1);
        check("R5 write landed", 64'(rd_data), 64'hCAFE_0077);

        // R9: write low word only; high word of same row unchanged.
        op(0, 0, 1, 100, 32'h0BAD_F00D, 1);
        op(0, 1, 0, 101, 0, 1);
        check("R9 other word", 64'(rd_data), 64'(pat(101, 1)));
        op(0, 1, 0, 100, 0, 1);
        check("R9 written word", 64'(rd_data), 64'h0BAD_F00D);

        // R6: sleep masks strobes, contents kept.
        hold = rd_data;
        op(1, 0, 1, 30, 32'hFFFF_0000, 1);
        op(1, 1, 0, 31, 0, 1);
        check("R6 out held", 64'(rd_data), 64'(hold));
        op(1, 1, 1, 250, 32'h1111_1111, 1);
        op(0, 1, 0, 30, 0, 1);
        check("R6 no write", 64'(rd_data), 64'(pat(30, 1)));
        op(0, 1, 0, 250, 0, 1);
        check("R6 contents kept", 64'(rd_data), 64'(pat(250, 1)));

        // Second pattern pass over all addresses.
        for (int a = 0; a < NW; a++) op(0, 0, 1, a, pat(a, 7), 0);
        for (int a = NW - 1; a >= 0; a--) begin
            op(0, 1, 0, a, 0, 0);
            check("R2 pass2", 64'(rd_data), 64'(model[a]));
        end

        // R1: reset clears output.
        rst = 1;
        @(negedge clk);
        check("R1 reset again", 64'(rd_data), 64'd0);
        rst = 0;

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule